// File: doc/BRIEF.md
# Serial-in latched-output shift register

The block takes one bit at a time on a shift clock. It moves the bits through a chain of stages and then, on a separate latch clock, copies the whole chain into a holding register. The parallel outputs show the holding register. They go high-impedance when the active-low enable is high. Because they are driven from the holding register, a word can be shifted in while the previous word stays steady on the pins.

An active-low clear empties the shift stages at once, without waiting for a clock edge. It leaves the holding register alone. The last stage is also brought out as a serial cascade bit, which is never tri-stated. Several instances chained cascade-to-input, with common clocks, act as one longer register. The two clocks may also be tied to one signal. In that case the holding register trails the shift stages by one edge.

Top module: `sipo_latch`

## Requirements
- R1: On each rising edge of `sclk` with `clr_n` high and `rst` low, `sin` is loaded into stage 0, and each stage k above 0 takes the old value of stage k-1.
- R2: On each rising edge of `lclk` with `rst` low, the holding register takes the value that all shift stages had just before that edge.
- R3: While `clr_n` is low, every shift stage reads zero. This starts at once, without any `sclk` edge, and `sclk` edges during the clear shift nothing in.
- R4: Shifting and clearing leave the holding register unchanged. `par_q` changes only after a rising edge of `lclk`.
- R5: With `oe_n` high, every bit of `par_q` is high-impedance. With `oe_n` low, `par_q[i]` drives holding bit i.
- R6: `ser_out` always equals the last shift stage (index WIDTH-1), whatever the level of `oe_n`.
- R7: When `sclk` and `lclk` rise on the same edge, the holding register captures the stage contents from before that edge, one step behind the shift chain.
- R8: `par_q[0]` shows the newest stage. After WIDTH shifts, the first bit shifted in appears on `par_q[WIDTH-1]`.
- R9: A rising `sclk` edge with `rst` high zeroes the shift stages. A rising `lclk` edge with `rst` high zeroes the holding register.
- R10: Two instances, the first one's `ser_out` feeding the second one's `sin`, with shared clocks, clear and enable, behave as one 2·WIDTH-bit register. The second instance holds the older bits.
- R11: `sin` is sampled at the rising edge of `sclk`. A change of `sin` right after that edge has no effect on the stage it loaded (zero hold time).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset, acting on each bank at its own clock edge |
| sclk | input | 1 | Shift clock, rising edge |
| lclk | input | 1 | Latch clock, rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of the shift stages only |
| oe_n | input | 1 | Active-low enable of the parallel outputs |
| sin | input | 1 | Serial data into stage 0 |
| par_q | output | WIDTH | Holding register bits, or high-impedance when disabled |
| ser_out | output | 1 | Last shift stage, for cascading |

## Verification
The shift step and the latch copy can fall on the same edge. The bench provokes this by raising both clocks in the same time step. It judges the result by checking that the parallel outputs then show the content the chain had before the edge, while the cascade bit already reflects the new shift. A clear held across a shift edge is also driven with `sin` high. This shows that the clear wins over the shift, and that the holding register keeps its old word until the next latch.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    // Default slice width of one register unit.
    localparam int unsigned SLICE_BITS = 8;

    // Drive state of the parallel output stage.
    typedef enum logic {
        DRV_ON  = 1'b0,
        DRV_HIZ = 1'b1
    } drv_e;

    // Map the active-low enable pin onto the drive state.
    function automatic drv_e drive_state(input logic en_n);
        return en_n ? DRV_HIZ : DRV_ON;
    endfunction

endpackage

// File: rtl/sipo_shift_bank.sv
module sipo_shift_bank #(
    parameter int unsigned WIDTH = sipo_pkg::SLICE_BITS
) (
    input  logic             sclk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             sin,
    output logic [WIDTH-1:0] stages
);

    localparam int unsigned LAST = WIDTH - 1;

    // Stage 0 is the newest bit; the chain moves toward index LAST.
    always_ff @(posedge sclk or negedge clr_n) begin
        if (!clr_n) begin
            stages <= '0;
        end else if (rst) begin
            stages <= '0;
        end else begin
            stages <= {stages[LAST-1:0], sin};
        end
    end

    // Checker state: set once a plain shift edge has passed since the last
    // reset or clear, so $past refers to a valid shift step.
    logic s_armed;
    always_ff @(posedge sclk or negedge clr_n) begin
        if (!clr_n) begin
            s_armed <= 1'b0;
        end else begin
            s_armed <= !rst;
        end
    end

    a_r1_shift_step: assert property (@(posedge sclk) disable iff (rst || !clr_n)
        s_armed |-> (stages[0] == $past(sin)) &&
                    (stages[LAST:1] == $past(stages[LAST-1:0])));

    a_r3_clear_zero: assert property (@(posedge sclk) disable iff (rst)
        !clr_n |-> (stages == '0));

endmodule

// File: rtl/sipo_hold_bank.sv
module sipo_hold_bank #(
    parameter int unsigned WIDTH = sipo_pkg::SLICE_BITS
) (
    input  logic             lclk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] hold
);

    always_ff @(posedge lclk) begin
        if (rst) begin
            hold <= '0;
        end else begin
            hold <= din;
        end
    end

    // Checker state: previous latch edge was outside reset.
    logic l_armed;
    always_ff @(posedge lclk) begin
        l_armed <= !rst;
    end

    a_r2_latch_copy: assert property (@(posedge lclk) disable iff (rst)
        l_armed |-> (hold == $past(din)));

    a_r9_hold_reset: assert property (@(posedge lclk)
        $past(rst) |-> (hold == '0));

endmodule

// File: rtl/sipo_latch.sv
module sipo_latch #(
    parameter int unsigned WIDTH = sipo_pkg::SLICE_BITS
) (
    input  logic             rst,
    input  logic             sclk,
    input  logic             lclk,
    input  logic             clr_n,
    input  logic             oe_n,
    input  logic             sin,
    output logic [WIDTH-1:0] par_q,
    output logic             ser_out
);

    import sipo_pkg::*;

    localparam int unsigned LAST = WIDTH - 1;

    logic [WIDTH-1:0] chain;
    logic [WIDTH-1:0] held;
    drv_e             drv;

    sipo_shift_bank #(.WIDTH(WIDTH)) u_shift (
        .sclk   (sclk),
        .rst    (rst),
        .clr_n  (clr_n),
        .sin    (sin),
        .stages (chain)
    );

    sipo_hold_bank #(.WIDTH(WIDTH)) u_hold (
        .lclk (lclk),
        .rst  (rst),
        .din  (chain),
        .hold (held)
    );

    // Cascade bit comes from the shift chain and ignores the enable.
    assign ser_out = chain[LAST];

    assign drv = drive_state(oe_n);

    for (genvar i = 0; i < WIDTH; i++) begin : g_outbuf
        assign par_q[i] = (drv == DRV_HIZ) ? 1'bz : held[i];
    end

    // Checker state: flips on every latch edge.
    logic l_tog = 1'b0;
    always_ff @(posedge lclk) begin
        l_tog <= ~l_tog;
    end

    a_r4_hold_only_on_latch: assert property (@(posedge sclk) disable iff (rst)
        (l_tog == $past(l_tog)) |-> $stable(held));

endmodule

// File: tb/tb_sipo_latch.sv
`timescale 1ns/1ps
module tb_sipo_latch;

    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, sclk, lclk, clr_n, oe_n, sin;
    logic tb_en;
    logic [W-1:0] tb_pat;
    wire  [W-1:0] bus_a;
    wire  [W-1:0] bus_b;
    wire  ser_a, ser_b;

    assign bus_a = tb_en ? tb_pat : {W{1'bz}};

    sipo_latch #(.WIDTH(W)) dut (
        .rst(rst), .sclk(sclk), .lclk(lclk), .clr_n(clr_n), .oe_n(oe_n),
        .sin(sin), .par_q(bus_a), .ser_out(ser_a)
    );

    sipo_latch #(.WIDTH(W)) dut_b (
        .rst(rst), .sclk(sclk), .lclk(lclk), .clr_n(clr_n), .oe_n(oe_n),
        .sin(ser_a), .par_q(bus_b), .ser_out(ser_b)
    );

    // Scoreboard item: which port to observe and its expected value.
    typedef struct {
        string       req;
        int          kind;   // 0 par A, 1 ser A, 2 par B, 3 ser B
        logic [15:0] exp;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    logic [15:0] obs;
    int n_checks = 0;
    int n_errs   = 0;
    bit done = 1'b0;

    // Reference model of the two chained units.
    logic [2*W-1:0] m_sh;
    logic [2*W-1:0] m_hold;

    // Monitor: pops and compares every pending item away from the clock edges used by the design.
    always @(posedge clk) begin
        while (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            case (cur.kind)
                0: obs = {8'h00, bus_a};
                1: obs = {15'd0, ser_a};
                2: obs = {8'h00, bus_b};
                default: obs = {15'd0, ser_b};
            endcase
            n_checks++;
            if (obs !== cur.exp) begin
                n_errs++;
                $display("FAIL %s: port %0d actual %h expected %h", cur.req, cur.kind, obs, cur.exp);
            end
        end
    end

    task automatic push(input string req, input int kind, input logic [15:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        exp_q.push_back(it);
    endtask

    task automatic expect_all(input string req);
        push(req, 0, {8'h00, m_hold[7:0]});
        push(req, 1, {15'd0, m_sh[7]});
        push(req, 2, {8'h00, m_hold[15:8]});
        push(req, 3, {15'd0, m_sh[15]});
    endtask

    task automatic shift(input logic b, input bit flip);
        sin = b;
        @(negedge clk);
        sclk = 1'b1;
        if (clr_n) m_sh = {m_sh[2*W-2:0], b};
        if (flip) begin
            #1 sin = ~b;
        end
        @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic latch();
        @(negedge clk);
        lclk = 1'b1;
        m_hold = m_sh;
        @(negedge clk);
        lclk = 1'b0;
    endtask

    task automatic both(input logic b);
        sin = b;
        @(negedge clk);
        sclk = 1'b1;
        lclk = 1'b1;
        m_hold = m_sh;
        m_sh = {m_sh[2*W-2:0], b};
        @(negedge clk);
        sclk = 1'b0;
        lclk = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    endtask

    // Watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sclk = 1'b0; lclk = 1'b0; clr_n = 1'b1;
        oe_n = 1'b0; sin = 1'b1; tb_en = 1'b0; tb_pat = '0;
        // R9: clock both banks with reset high and sin high
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); sclk = 1'b1; lclk = 1'b1;
            @(negedge clk); sclk = 1'b0; lclk = 1'b0;
        end
        rst = 1'b0;
        m_sh = '0; m_hold = '0;
        @(negedge clk);
        expect_all("R9");
        @(negedge clk);

        // R8: a single one followed by seven zeros lands on the top bit
        shift(1'b1, 0);
        for (int k = 0; k < W - 1; k++) shift(1'b0, 0);
        latch();
        push("R8", 0, 16'h0080);
        @(negedge clk);

        // R1, R6: pattern 0xB4, cascade bit after each step
        for (int k = W - 1; k >= 0; k--) begin
            shift(logic'((8'hB4 >> k) & 1), 0);
            push("R6", 1, {15'd0, m_sh[7]});
        end
        push("R1", 1, {15'd0, 1'b1});
        latch();
        expect_all("R2");
        push("R1", 0, 16'h00B4);
        @(negedge clk);

        // R4: more shifts without a latch leave the outputs alone
        shift(1'b0, 0); shift(1'b1, 0); shift(1'b1, 0);
        push("R4", 0, 16'h00B4);
        @(negedge clk);

        // R3: clear acts without a shift edge
        clr_n = 1'b0;
        m_sh = '0;
        push("R3", 1, 16'h0000);
        push("R3", 3, 16'h0000);
        push("R4", 0, 16'h00B4);
        @(negedge clk);
        // R3: shift edges during clear load nothing
        shift(1'b1, 0);
        shift(1'b1, 0);
        push("R3", 1, 16'h0000);
        push("R4", 0, 16'h00B4);
        @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        latch();
        push("R3", 0, 16'h0000);
        expect_all("R3");
        @(negedge clk);

        // R5, R6: load 0xA5 and disable outputs
        for (int k = W - 1; k >= 0; k--) shift(logic'((8'hA5 >> k) & 1), 0);
        latch();
        push("R5", 0, 16'h00A5);
        @(negedge clk);
        oe_n = 1'b1;
        tb_en = 1'b1; tb_pat = 8'h5A;
        push("R5", 0, 16'h005A);
        push("R6", 1, {15'd0, m_sh[7]});
        @(negedge clk);
        tb_pat = 8'h00;
        push("R5", 0, 16'h0000);
        push("R6", 1, 16'h0001);
        @(negedge clk);
        tb_en = 1'b0;
        oe_n = 1'b0;
        @(negedge clk);
        push("R5", 0, 16'h00A5);
        @(negedge clk);

        // R7: tied clocks, holding register one step behind
        both(1'b0);
        push("R7", 0, 16'h00A5);
        expect_all("R7");
        both(1'b1);
        push("R7", 0, 16'h004A);
        expect_all("R7");
        both(1'b1);
        expect_all("R7");
        both(1'b0);
        expect_all("R7");
        @(negedge clk);

        // R11: sin flips right after each shift edge
        for (int k = W - 1; k >= 0; k--) shift(logic'((8'h3C >> k) & 1), 1);
        latch();
        push("R11", 0, 16'h003C);
        expect_all("R11");
        @(negedge clk);

        // R10: 16 bits through the chained pair
        for (int k = 15; k >= 0; k--) shift(logic'((16'hC3A5 >> k) & 1), 0);
        latch();
        push("R10", 0, 16'h00A5);
        push("R10", 2, 16'h00C3);
        push("R10", 3, 16'h0001);
        expect_all("R10");
        @(negedge clk);

        // R10, R9: mid-run reset clears both units
        rst = 1'b1;
        @(negedge clk); sclk = 1'b1; lclk = 1'b1;
        @(negedge clk); sclk = 1'b0; lclk = 1'b0; rst = 1'b0;
        m_sh = '0; m_hold = '0;
        expect_all("R9");
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule